// File: doc/BRIEF.md
# Monitor Serial Command Target

This block is the two-wire serial (I2C, fast mode) target through which a host controls a supply monitor and reads back its measurements. It oversamples the bus with the system clock. It detects start and stop conditions, shifts bytes in and out, and drives the data line low through an open-drain enable to acknowledge or to send a 0 bit.

A host writes a command word that selects which channels the conversion sequencer converts and whether it converts once or continuously. A write can instead point at one of three extended registers and load it with the following byte. On a read, the block returns the latest voltage and current results, or a status byte.

The 7-bit target address has a fixed high part and two low bits taken from a strap input. A read that arrives while a single-shot conversion is still pending is refused at the address stage. Result, status, busy and valid inputs come from the conversion sequencer. The command and extended register outputs go back to it.

Top module: `i2cm_target`

## Requirements
- R1: The block acknowledges (pulls the data line low in the ninth clock) an address byte whose upper seven bits equal 1101 0 followed by strap_i[1], strap_i[0]. Any other address is not acknowledged, and the bytes that follow it are neither acknowledged nor stored.
- R2: After reset, cmd_o is 0, alert_en_o is 8'h04, alert_th_o is 0, ctrl_o is 0, and the data line is released.
- R3: A first data byte with bit 7 = 0 is loaded into cmd_o as bits 6:0, and cmd_wr_o pulses high for exactly one clock. Bit 0 = voltage continuous, bit 1 = voltage once, bit 2 = current continuous, bit 3 = current once, bit 4 = range, bit 6 = status read.
- R4: A first data byte with bit 7 = 1 selects a register by its bits 1:0: 01 alert enable, 10 alert threshold, 11 control. The second byte is written into that register only, and the other registers keep their values.
- R5: An extended select of 00, and every data byte after the second, are acknowledged and change no register.
- R6: An address-with-write followed directly by stop (quick command) is acknowledged and changes no register.
- R7: While oneshot_busy_i is high, an address-with-read is not acknowledged. An address-with-write is still acknowledged.
- R8: With data_valid_i low and status read not selected, a read is acknowledged and returns all-zero bytes.
- R9: With command bit 6 set, the first read byte is status_i, whatever channels are selected.
- R10: With only voltage bits (0 or 1) set, a read returns volt_i[11:4], then {volt_i[3:0],4'b0}. With only current bits (2 or 3) set, it returns the same layout from curr_i. With no channel bit set, it returns zeros.
- R11: With a voltage bit and a current bit both set, a read returns three bytes: volt_i[11:4], {volt_i[3:0],curr_i[11:8]}, curr_i[7:0].
- R12: The block asserts the data line only while the clock line is low. After the host answers a read byte with NACK, the block releases the line and waits for stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | High to pull the data line low |
| strap_i | input | 2 | Low two address bits |
| oneshot_busy_i | input | 1 | A single-shot conversion is pending |
| data_valid_i | input | 1 | At least one conversion has completed |
| volt_i | input | 12 | Latest voltage result |
| curr_i | input | 12 | Latest current result |
| status_i | input | 8 | Status byte from the sequencer |
| cmd_o | output | 7 | Command word |
| cmd_wr_o | output | 1 | One-clock pulse when the command word is written |
| alert_en_o | output | 8 | Alert enable register |
| alert_th_o | output | 8 | Alert threshold register |
| ctrl_o | output | 8 | Control register |

## Verification
The hardest case to reach is the byte-to-byte handover in a multi-byte read. The next byte must already be loaded when the host's acknowledge is sampled on a clock rise, and the block must drive its first bit on the very next fall. Only a read of three acknowledged bytes exercises the shift between every pair of bytes. The stimulus therefore writes each of the sixteen combinations of the four channel bits and reads back the full frame that each one implies. This covers empty, single-channel and combined frames in the same run. An address sweep of all 128 values with quick commands covers the address decode and the no-change rule at once.

// File: rtl/i2cm_pkg.sv
// Shared types and command-bit positions for the monitor serial target.
package i2cm_pkg;

    // Link layer states: idle, receive byte, send ack, send byte, take ack, wait stop.
    typedef enum logic [2:0] {
        LK_IDLE   = 3'd0,
        LK_RX     = 3'd1,
        LK_ACK_TX = 3'd2,
        LK_TX     = 3'd3,
        LK_ACK_RX = 3'd4,
        LK_WAIT   = 3'd5
    } link_state_t;

    // Extended register selector carried in bits 1:0 of a select byte.
    typedef enum logic [1:0] {
        XR_NONE     = 2'b00,
        XR_ALERT_EN = 2'b01,
        XR_ALERT_TH = 2'b10,
        XR_CTRL     = 2'b11
    } xreg_sel_t;

    localparam int CMD_W      = 7;
    localparam int CB_V_CONT  = 0;
    localparam int CB_V_ONCE  = 1;
    localparam int CB_I_CONT  = 2;
    localparam int CB_I_ONCE  = 3;
    localparam int CB_STATUS  = 6;

endpackage

// File: rtl/i2cm_sync.sv
// Bus front end: brings scl/sda into the clock domain through STAGES flops
// and flags clock edges and start/stop conditions.
// Assumes bus phases last several system clocks.
module i2cm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    // One flop per synchronizer stage, both lines alike.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                scl_q[g] <= 1'b1;
                sda_q[g] <= 1'b1;
            end else if (g == 0) begin
                scl_q[g] <= scl_i;
                sda_q[g] <= sda_i;
            end else begin
                scl_q[g] <= scl_q[(g == 0) ? 0 : g-1];
                sda_q[g] <= sda_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    // Previous synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2cm_link.sv
// Byte-level protocol engine: address match, byte receive, ack generation,
// byte transmit and host-ack sampling.
// Assumes the register block answers rd_load/rd_adv within one clock.
module i2cm_link
    import i2cm_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b11010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_s,
    input  logic [1:0] strap_i,
    input  logic       rd_block,
    input  logic [7:0] rd_byte,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic       wr_first,
    output logic [7:0] wr_data,
    output logic       rd_load,
    output logic       rd_adv
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    link_state_t state;
    logic [3:0]  cnt;
    logic [7:0]  sh;
    logic [7:0]  txsh;
    logic        in_addr;
    logic        is_rd;
    logic        acked;
    logic [1:0]  wr_idx;
    logic        addr_hit;

    assign addr_hit = (sh[7:1] == {ADDR_PREFIX, strap_i});

    // Protocol sequencing; start and stop override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LK_IDLE;
            cnt      <= '0;
            sh       <= '0;
            txsh     <= '0;
            in_addr  <= 1'b0;
            is_rd    <= 1'b0;
            acked    <= 1'b0;
            wr_idx   <= '0;
            sda_oe   <= 1'b0;
            wr_stb   <= 1'b0;
            wr_first <= 1'b0;
            wr_data  <= '0;
            rd_load  <= 1'b0;
            rd_adv   <= 1'b0;
        end else begin
            wr_stb  <= 1'b0;
            rd_load <= 1'b0;
            rd_adv  <= 1'b0;
            if (start_det) begin
                state   <= LK_RX;
                in_addr <= 1'b1;
                cnt     <= '0;
                wr_idx  <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= LK_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    LK_RX: begin
                        if (scl_rise && cnt < BYTE_BITS) begin
                            sh  <= {sh[6:0], sda_s};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == BYTE_BITS) begin
                            cnt   <= '0;
                            state <= LK_ACK_TX;
                            if (in_addr) begin
                                in_addr <= 1'b0;
                                is_rd   <= sh[0];
                                if (addr_hit && !(sh[0] && rd_block)) begin
                                    acked   <= 1'b1;
                                    sda_oe  <= 1'b1;
                                    rd_load <= sh[0];
                                end else begin
                                    acked <= 1'b0;
                                end
                            end else begin
                                acked    <= 1'b1;
                                sda_oe   <= 1'b1;
                                wr_stb   <= 1'b1;
                                wr_data  <= sh;
                                wr_first <= (wr_idx == 2'd0);
                                if (wr_idx != 2'd3) wr_idx <= wr_idx + 2'd1;
                            end
                        end
                    end
                    LK_ACK_TX: begin
                        if (scl_fall) begin
                            if (!acked) begin
                                sda_oe <= 1'b0;
                                state  <= LK_WAIT;
                            end else if (is_rd) begin
                                sda_oe <= ~rd_byte[7];
                                txsh   <= {rd_byte[6:0], 1'b0};
                                cnt    <= 4'd1;
                                state  <= LK_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= LK_RX;
                            end
                        end
                    end
                    LK_TX: begin
                        if (scl_fall) begin
                            if (cnt == BYTE_BITS) begin
                                sda_oe <= 1'b0;
                                state  <= LK_ACK_RX;
                            end else begin
                                sda_oe <= ~txsh[7];
                                txsh   <= {txsh[6:0], 1'b0};
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    LK_ACK_RX: begin
                        if (scl_rise) begin
                            acked  <= ~sda_s;
                            rd_adv <= ~sda_s;
                        end else if (scl_fall) begin
                            if (acked) begin
                                sda_oe <= ~rd_byte[7];
                                txsh   <= {rd_byte[6:0], 1'b0};
                                cnt    <= 4'd1;
                                state  <= LK_TX;
                            end else begin
                                state <= LK_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cm_regs.sv
// Register decode and read framing: command word, three extended registers,
// and the byte frame returned on a read.
// Assumes wr_stb, rd_load and rd_adv are single-clock strobes.
module i2cm_regs
    import i2cm_pkg::*;
#(
    parameter int         DATA_W    = 12,
    parameter logic [7:0] ALERT_RST = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              wr_first,
    input  logic [7:0]        wr_data,
    input  logic              rd_load,
    input  logic              rd_adv,
    input  logic              data_valid_i,
    input  logic [DATA_W-1:0] volt_i,
    input  logic [DATA_W-1:0] curr_i,
    input  logic [7:0]        status_i,
    output logic [7:0]        rd_byte,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              cmd_wr_o,
    output logic [7:0]        alert_en_o,
    output logic [7:0]        alert_th_o,
    output logic [7:0]        ctrl_o
);
    localparam int FRAME_W = 8 * ((2 * DATA_W + 7) / 8);

    xreg_sel_t          ext_sel;
    logic               ext_pend;
    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] next_frame;
    logic               want_v;
    logic               want_i;

    assign want_v = cmd_o[CB_V_CONT] | cmd_o[CB_V_ONCE];
    assign want_i = cmd_o[CB_I_CONT] | cmd_o[CB_I_ONCE];

    // Decode written bytes into the command word or an extended register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o      <= '0;
            cmd_wr_o   <= 1'b0;
            alert_en_o <= ALERT_RST;
            alert_th_o <= '0;
            ctrl_o     <= '0;
            ext_sel    <= XR_NONE;
            ext_pend   <= 1'b0;
        end else begin
            cmd_wr_o <= 1'b0;
            if (wr_stb) begin
                if (wr_first) begin
                    if (!wr_data[7]) begin
                        cmd_o    <= wr_data[CMD_W-1:0];
                        cmd_wr_o <= 1'b1;
                        ext_pend <= 1'b0;
                    end else begin
                        ext_sel  <= xreg_sel_t'(wr_data[1:0]);
                        ext_pend <= 1'b1;
                    end
                end else if (ext_pend) begin
                    ext_pend <= 1'b0;
                    case (ext_sel)
                        XR_ALERT_EN: alert_en_o <= wr_data;
                        XR_ALERT_TH: alert_th_o <= wr_data;
                        XR_CTRL:     ctrl_o     <= wr_data;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Build the read frame from the selected channels, MSB first.
    always_comb begin
        next_frame = '0;
        if (cmd_o[CB_STATUS]) begin
            next_frame[FRAME_W-1 -: 8] = status_i;
        end else if (data_valid_i) begin
            if (want_v && want_i) begin
                next_frame[FRAME_W-1 -: DATA_W]        = volt_i;
                next_frame[FRAME_W-1-DATA_W -: DATA_W] = curr_i;
            end else if (want_v) begin
                next_frame[FRAME_W-1 -: DATA_W] = volt_i;
            end else if (want_i) begin
                next_frame[FRAME_W-1 -: DATA_W] = curr_i;
            end
        end
    end

    // Capture the frame at address ack, step one byte per host ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
        end else if (rd_load) begin
            frame <= next_frame;
        end else if (rd_adv) begin
            frame <= frame << 8;
        end
    end

    assign rd_byte = frame[FRAME_W-1 -: 8];

endmodule

// File: rtl/i2cm_target.sv
// Top of the monitor serial target: front end, protocol engine, registers.
// Assumes scl/sda phases span at least four system clocks.
module i2cm_target #(
    parameter logic [4:0] ADDR_PREFIX = 5'b11010,
    parameter int         DATA_W      = 12,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ALERT_RST   = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        strap_i,
    input  logic              oneshot_busy_i,
    input  logic              data_valid_i,
    input  logic [DATA_W-1:0] volt_i,
    input  logic [DATA_W-1:0] curr_i,
    input  logic [7:0]        status_i,
    output logic [6:0]        cmd_o,
    output logic              cmd_wr_o,
    output logic [7:0]        alert_en_o,
    output logic [7:0]        alert_th_o,
    output logic [7:0]        ctrl_o
);
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       wr_stb;
    logic       wr_first;
    logic [7:0] wr_data;
    logic       rd_load;
    logic       rd_adv;
    logic [7:0] rd_byte;

    i2cm_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cm_link #(.ADDR_PREFIX(ADDR_PREFIX)) link_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .strap_i   (strap_i),
        .rd_block  (oneshot_busy_i),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe_o),
        .wr_stb    (wr_stb),
        .wr_first  (wr_first),
        .wr_data   (wr_data),
        .rd_load   (rd_load),
        .rd_adv    (rd_adv)
    );

    i2cm_regs #(.DATA_W(DATA_W), .ALERT_RST(ALERT_RST)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb       (wr_stb),
        .wr_first     (wr_first),
        .wr_data      (wr_data),
        .rd_load      (rd_load),
        .rd_adv       (rd_adv),
        .data_valid_i (data_valid_i),
        .volt_i       (volt_i),
        .curr_i       (curr_i),
        .status_i     (status_i),
        .rd_byte      (rd_byte),
        .cmd_o        (cmd_o),
        .cmd_wr_o     (cmd_wr_o),
        .alert_en_o   (alert_en_o),
        .alert_th_o   (alert_th_o),
        .ctrl_o       (ctrl_o)
    );

endmodule

// File: rtl/i2cm_target_chk.sv
// Property checker for i2cm_target, attached by bind below.
module i2cm_target_chk #(
    parameter logic [7:0] ALERT_RST = 8'h04
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic [6:0] cmd_o,
    input logic       cmd_wr_o,
    input logic [7:0] alert_en_o,
    input logic [7:0] alert_th_o,
    input logic [7:0] ctrl_o
);
    // R2
    reset_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cmd_o == 7'd0 && alert_en_o == ALERT_RST &&
                           alert_th_o == 8'd0 && ctrl_o == 8'd0 && !sda_oe_o));

    // R3
    cmd_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_o) |-> cmd_wr_o);

    // R3
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_o |=> !cmd_wr_o);

    // R4
    one_xreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({alert_en_o != $past(alert_en_o),
                    alert_th_o != $past(alert_th_o),
                    ctrl_o     != $past(ctrl_o)}) <= 1);

    // R12
    drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

endmodule

bind i2cm_target i2cm_target_chk #(.ALERT_RST(ALERT_RST)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .cmd_o      (cmd_o),
    .cmd_wr_o   (cmd_wr_o),
    .alert_en_o (alert_en_o),
    .alert_th_o (alert_th_o),
    .ctrl_o     (ctrl_o)
);

// File: tb/i2cm_target_tb_top.sv
module i2cm_target_tb_top;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'b01;
    logic        busy = 1'b0;
    logic        valid = 1'b1;
    logic [11:0] volt = 12'hA5C;
    logic [11:0] curr = 12'h3E7;
    logic [7:0]  stat = 8'h5B;
    logic        sda_oe;
    logic [6:0]  cmd;
    logic        cmd_wr;
    logic [7:0]  aen, ath, ctl;
    logic        sda_line;
    int          errors = 0;
    int          checks = 0;
    int          pulses = 0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2cm_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(strap), .oneshot_busy_i(busy),
        .data_valid_i(valid), .volt_i(volt), .curr_i(curr), .status_i(stat),
        .cmd_o(cmd), .cmd_wr_o(cmd_wr), .alert_en_o(aen), .alert_th_o(ath),
        .ctrl_o(ctl)
    );

    always @(posedge clk) if (rst_n && cmd_wr) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        ack = ~sda_line;
        wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl_m = 1'b0;
        end
        wq(Q); sda_m = ~mack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0;
        wq(Q); sda_m = 1'b1;
    endtask

    // Write transaction: address plus n bytes, every ack expected.
    task automatic wr_seq(input string req, input int n, input logic [7:0] b0,
                          input logic [7:0] b1, input logic [7:0] b2);
        logic ack;
        logic [7:0] d [3];
        d[0] = b0; d[1] = b1; d[2] = b2;
        bus_start();
        wr_byte({5'b11010, strap, 1'b0}, ack);
        chk({req, " addr ack"}, 32'(ack), 32'd1);
        for (int k = 0; k < n; k++) begin
            wr_byte(d[k], ack);
            chk({req, " data ack"}, 32'(ack), 32'd1);
        end
        bus_stop();
    endtask

    // Read transaction of n bytes compared with the top bytes of exp.
    task automatic rd_chk(input string req, input int n, input logic [23:0] exp);
        logic ack;
        logic [7:0] b;
        bus_start();
        wr_byte({5'b11010, strap, 1'b1}, ack);
        chk({req, " read addr ack"}, 32'(ack), 32'd1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k < n - 1, b);
            chk({req, " read byte"}, 32'(b), 32'(exp[23-8*k -: 8]));
        end
        chk("R12 released after host NACK", 32'(sda_oe), 32'd0);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ack;
        logic [23:0] ef;
        int nb;
        int p0;
        wq(5); rst_n = 1'b1; wq(2);
        // R2 reset state
        chk("R2 cmd", 32'(cmd), 32'd0);
        chk("R2 alert enable", 32'(aen), 32'h04);
        chk("R2 threshold", 32'(ath), 32'd0);
        chk("R2 control", 32'(ctl), 32'd0);
        chk("R2 line released", 32'(sda_oe), 32'd0);

        // R1 / R6 sweep of all addresses with quick commands
        for (int a = 0; a < 128; a++) begin
            bus_start();
            wr_byte({a[6:0], 1'b0}, ack);
            bus_stop();
            chk("R1 address sweep ack", 32'(ack), 32'(a == 7'h69));
        end
        chk("R6 quick cmd no change cmd", 32'(cmd), 32'd0);
        chk("R6 quick cmd no change regs", {8'h0, aen, ath, ctl}, 32'h00040000);
        chk("R6 no command pulse", 32'(pulses), 32'd0);
        chk("R12 idle released", 32'(sda_oe), 32'd0);

        // R1 each strap value against the four candidate addresses
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int c = 0; c < 4; c++) begin
                bus_start();
                wr_byte({5'b11010, 2'(c), 1'b0}, ack);
                bus_stop();
                chk("R1 strap decode", 32'(ack), 32'(c == s));
            end
        end
        strap = 2'b01;

        // R1 mismatched address with data: no ack, nothing stored
        bus_start();
        wr_byte({5'b11010, 2'b10, 1'b0}, ack);
        chk("R1 foreign addr nack", 32'(ack), 32'd0);
        wr_byte(8'h05, ack);
        chk("R1 foreign data nack", 32'(ack), 32'd0);
        bus_stop();
        chk("R1 foreign write ignored", 32'(cmd), 32'd0);

        // R3 command write and pulse
        p0 = pulses;
        wr_seq("R3", 1, 8'h05, 8'h00, 8'h00);
        chk("R3 cmd value", 32'(cmd), 32'h05);
        chk("R3 one pulse", 32'(pulses - p0), 32'd1);

        // R4 extended registers
        wr_seq("R4", 2, 8'h81, 8'h03, 8'h00);
        chk("R4 alert enable", {8'h0, aen, ath, ctl}, 32'h00030000);
        wr_seq("R4", 2, 8'h82, 8'h77, 8'h00);
        chk("R4 threshold", {8'h0, aen, ath, ctl}, 32'h00037700);
        wr_seq("R4", 2, 8'h83, 8'h3C, 8'h00);
        chk("R4 control", {8'h0, aen, ath, ctl}, 32'h0003773C);
        chk("R4 cmd untouched", 32'(cmd), 32'h05);

        // R5 ignored selector and surplus bytes
        wr_seq("R5", 2, 8'h80, 8'h55, 8'h00);
        chk("R5 select 00 ignored", {8'h0, aen, ath, ctl}, 32'h0003773C);
        wr_seq("R5", 3, 8'h82, 8'h11, 8'h99);
        chk("R5 surplus byte ignored", {8'h0, aen, ath, ctl}, 32'h0003113C);
        wr_seq("R5", 3, 8'h01, 8'h22, 8'h33);
        chk("R5 surplus after command", 32'(cmd), 32'h01);
        chk("R5 regs after command", {8'h0, aen, ath, ctl}, 32'h0003113C);

        // R7 read refused while busy, write still accepted
        busy = 1'b1;
        bus_start();
        wr_byte({5'b11010, strap, 1'b1}, ack);
        bus_stop();
        chk("R7 busy read nack", 32'(ack), 32'd0);
        bus_start();
        wr_byte({5'b11010, strap, 1'b0}, ack);
        bus_stop();
        chk("R7 busy write ack", 32'(ack), 32'd1);
        busy = 1'b0;

        // R8 no conversion yet: zeros
        valid = 1'b0;
        wr_seq("R8", 1, 8'h05, 8'h00, 8'h00);
        rd_chk("R8 zeros before first result", 3, 24'h0);
        valid = 1'b1;

        // R9 status byte
        wr_seq("R9", 1, 8'h45, 8'h00, 8'h00);
        rd_chk("R9 status", 1, {stat, 16'h0});

        // R10 / R11 sweep of all channel-bit combinations
        for (int c = 0; c < 16; c++) begin
            logic wv, wi;
            wv = c[0] | c[1];
            wi = c[2] | c[3];
            if (wv && wi) begin
                ef = {volt, curr}; nb = 3;
            end else if (wv) begin
                ef = {volt, 12'h0}; nb = 2;
            end else if (wi) begin
                ef = {curr, 12'h0}; nb = 2;
            end else begin
                ef = 24'h0; nb = 2;
            end
            wr_seq("R3", 1, {4'h0, 4'(c)}, 8'h00, 8'h00);
            chk("R3 channel bits", 32'(cmd), 32'(c));
            if (wv && wi) rd_chk("R11 combined frame", nb, ef);
            else          rd_chk("R10 single frame", nb, ef);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule